// File: doc/BRIEF.md
# Flag-Producing Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for a processor datapath. It takes two 32-bit operands and a 2-bit operation select. It returns a 32-bit result and a 4-bit condition flag vector that later condition-evaluation logic decodes. The four operations are addition, subtraction, bitwise AND and bitwise OR.

Addition and subtraction run through one shared adder. For subtraction the second operand is inverted and the carry-in is forced to one, so the carry flag on a subtraction means "no borrow". The flags report whether the result is negative, whether it is zero, the adder's carry out, and signed overflow. Carry and overflow only have meaning for the arithmetic operations and read as zero for the two bitwise ones.

Top module: `flag_alu`

## Requirements
- R1: With op_sel = 2'b00 (add), result equals (a + b) modulo 2^32.
- R2: With op_sel = 2'b01 (subtract), result equals (a - b) modulo 2^32.
- R3: With op_sel = 2'b10 (AND), result equals a & b.
- R4: With op_sel = 2'b11 (OR), result equals a | b.
- R5: flags[3] (negative) always equals result[31].
- R6: flags[2] (zero) is 1 exactly when all 32 result bits are 0.
- R7: flags[1] (carry) is the carry out of bit 31 of the adder. On add it is 1 when the unsigned sum exceeds 0xFFFFFFFF. On subtract it is 1 when a >= b as unsigned values, so 1 - 1 sets it.
- R8: flags[0] (overflow) is 1 only on add or subtract when the signed result is out of range. On add this happens when a and b share a sign bit that the result lacks. On subtract it happens when a and b differ in sign and the result's sign differs from a's sign.
- R9: With op_sel = 2'b10 or 2'b11, flags[1] and flags[0] are 0.
- R10: The block holds no state. The result and flags follow a change of the inputs without any clock edge.
- R11: The design has exactly one adder. Fixed cases: 0 + 0 gives 0 with flags 4'h4. 0 + 0xFFFFFFFF gives 0xFFFFFFFF with flags 4'h8. 1 + 0xFFFFFFFF gives 0 with flags 4'h6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| op_sel | input | 2 | Operation: 00 add, 01 subtract, 10 AND, 11 OR |
| result | output | 32 | Operation result |
| flags | output | 4 | {negative, zero, carry, overflow} |

## Verification
Each result and each flag is due in the same cycle that its stimulus is applied, with zero register stages between input and output. The bench drives new operands on the falling clock edge. It samples one nanosecond later, so each check sees settled combinational values and never depends on an edge. One directed case changes the inputs twice within a single clock phase. It checks the outputs after each change, which shows that no clock edge is needed.

// File: rtl/alu_pkg.sv
// Package: shared operation encoding and flag bit positions for the ALU.
// Assumes a 2-bit select. The flag positions are fixed because downstream
// condition logic decodes them.
package alu_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_AND = 2'b10,
        OP_OR  = 2'b11
    } alu_op_e;

    localparam int FLAG_W   = 4;
    localparam int FLAG_NEG = 3;
    localparam int FLAG_ZER = 2;
    localparam int FLAG_CRY = 1;
    localparam int FLAG_OVF = 0;

    // Purpose: tell whether an operation uses the shared adder.
    function automatic logic op_is_arith(input alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/alu_operand_prep.sv
// Module: conditions the second operand for the shared adder.
// For subtraction it inverts b and requests a carry-in of one, so that
// the adder computes a + ~b + 1. For other operations b passes unchanged
// and the carry-in is zero. Purely combinational.
module alu_operand_prep
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_eff,
    output logic         carry_in
);

    // Purpose: select inverted or plain operand and the matching carry-in.
    always_comb begin
        case (op)
            OP_SUB: begin
                b_eff    = ~b_in;
                carry_in = 1'b1;
            end
            default: begin
                b_eff    = b_in;
                carry_in = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu_shared_adder.sv
// Module: the single adder of the ALU, used by both add and subtract.
// Produces the W-bit sum, the carry out of the top bit, and the signed
// overflow indication computed from the operands the adder actually sees.
// Assumes the operand has already been conditioned for subtraction.
module alu_shared_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);

    localparam int MSB = W - 1;

    logic [W:0] wide_sum;

    // Purpose: one carry-propagating addition, extended by one bit for carry.
    always_comb begin
        wide_sum = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    end

    // Purpose: split the extended sum and derive signed overflow.
    always_comb begin
        sum  = wide_sum[MSB:0];
        cout = wide_sum[W];
        ovf  = (x[MSB] == y[MSB]) && (wide_sum[MSB] != x[MSB]);
    end

endmodule

// File: rtl/alu_logic_unit.sv
// Module: bitwise part of the ALU (AND and OR).
// Only the low select bit matters here. The top-level mux decides when
// this output is used. Purely combinational.
module alu_logic_unit #(
    parameter int W = 32
) (
    input  logic         pick_or,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    // Purpose: choose between bitwise AND and bitwise OR.
    always_comb begin
        y = pick_or ? (a | b) : (a & b);
    end

endmodule

// File: rtl/alu_flag_gen.sv
// Module: forms the 4-bit condition vector {negative, zero, carry, overflow}.
// Negative and zero come from the final result for every operation. Carry
// and overflow pass through only for arithmetic operations and are forced
// to zero otherwise.
module alu_flag_gen
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              arith,
    input  logic [W-1:0]      res,
    input  logic              add_cout,
    input  logic              add_ovf,
    output logic [FLAG_W-1:0] flags
);

    // Purpose: assemble the flag vector at its fixed bit positions.
    always_comb begin
        flags           = '0;
        flags[FLAG_NEG] = res[W-1];
        flags[FLAG_ZER] = (res == '0);
        flags[FLAG_CRY] = arith & add_cout;
        flags[FLAG_OVF] = arith & add_ovf;
    end

endmodule

// File: rtl/flag_alu.sv
// Module: top of the flag-producing ALU. It wires operand conditioning, the
// one shared adder, the bitwise unit and flag generation, and muxes the
// result by operation. It has no clock and no state. Assertions next to
// the output mux check results and flags against the port operands.
module flag_alu
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    input  logic [1:0]        op_sel,
    output logic [W-1:0]      result,
    output logic [FLAG_W-1:0] flags
);

    localparam int MSB = W - 1;

    alu_op_e      op;
    logic [W-1:0] b_eff;
    logic         carry_in;
    logic [W-1:0] add_sum;
    logic         add_cout;
    logic         add_ovf;
    logic [W-1:0] logic_res;
    logic         arith;

    // Purpose: decode the raw select into the operation type.
    always_comb begin
        op    = alu_op_e'(op_sel);
        arith = op_is_arith(op);
    end

    alu_operand_prep #(.W(W)) u_prep (
        .op       (op),
        .b_in     (b),
        .b_eff    (b_eff),
        .carry_in (carry_in)
    );

    alu_shared_adder #(.W(W)) u_adder (
        .x    (a),
        .y    (b_eff),
        .cin  (carry_in),
        .sum  (add_sum),
        .cout (add_cout),
        .ovf  (add_ovf)
    );

    alu_logic_unit #(.W(W)) u_logic (
        .pick_or (op_sel[0]),
        .a       (a),
        .b       (b),
        .y       (logic_res)
    );

    // Purpose: pick the adder or bitwise output as the result.
    always_comb begin
        result = arith ? add_sum : logic_res;
    end

    alu_flag_gen #(.W(W)) u_flags (
        .arith    (arith),
        .res      (result),
        .add_cout (add_cout),
        .add_ovf  (add_ovf),
        .flags    (flags)
    );

    // Purpose: check results and flags against the port-level operands.
    always_comb begin
        // R1
        if (op == OP_ADD) add_result_chk: assert (result == a + b)
            else $error("add result mismatch");
        // R2
        if (op == OP_SUB) sub_result_chk: assert (result == a - b)
            else $error("sub result mismatch");
        // R3
        if (op == OP_AND) and_result_chk: assert (result == (a & b))
            else $error("and result mismatch");
        // R4
        if (op == OP_OR) or_result_chk: assert (result == (a | b))
            else $error("or result mismatch");
        // R7
        if (op == OP_ADD) add_carry_chk: assert (flags[FLAG_CRY] == (result < a))
            else $error("add carry mismatch");
        // R7
        if (op == OP_SUB) sub_carry_chk: assert (flags[FLAG_CRY] == (a >= b))
            else $error("sub carry mismatch");
        // R8
        if (op == OP_ADD) add_overflow_chk: assert (flags[FLAG_OVF] ==
                ((a[MSB] == b[MSB]) && (result[MSB] != a[MSB])))
            else $error("add overflow mismatch");
        // R8
        if (op == OP_SUB) sub_overflow_chk: assert (flags[FLAG_OVF] ==
                ((a[MSB] != b[MSB]) && (result[MSB] != a[MSB])))
            else $error("sub overflow mismatch");
        // R9
        if (!arith) no_arith_flags_chk: assert (flags[FLAG_CRY:FLAG_OVF] == 2'b00)
            else $error("carry or overflow set on bitwise op");
        // R6
        zero_flag_chk: assert (flags[FLAG_ZER] == (result == '0))
            else $error("zero flag mismatch");
    end

endmodule

// File: tb/flag_alu_tb.sv
// Bench: directed corner cases plus seeded random vectors, checked against
// an independent reference function. It drives on the falling edge and
// samples one nanosecond later.
module flag_alu_tb;

    logic        clk = 1'b0;
    logic [31:0] a, b;
    logic [1:0]  op_sel;
    logic [31:0] result;
    logic [3:0]  flags;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    flag_alu u_dut (
        .a      (a),
        .b      (b),
        .op_sel (op_sel),
        .result (result),
        .flags  (flags)
    );

    // Reference model: returns {flags, result} computed from the requirements.
    function automatic logic [35:0] ref_model(input logic [1:0] op,
                                              input logic [31:0] x,
                                              input logic [31:0] y);
        logic [32:0] s;
        logic [31:0] r;
        logic c, v;
        c = 1'b0; v = 1'b0;
        case (op)
            2'b00: begin
                s = {1'b0, x} + {1'b0, y};
                r = s[31:0]; c = s[32];
                v = (x[31] == y[31]) && (r[31] != x[31]);
            end
            2'b01: begin
                r = x - y; c = (x >= y);
                v = (x[31] != y[31]) && (r[31] != x[31]);
            end
            2'b10: r = x & y;
            default: r = x | y;
        endcase
        return {r[31], (r == 32'd0), c, v, r};
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h (op=%b a=%h b=%h)",
                     req, act, exp, op_sel, a, b);
        end
    endtask

    // Drive one vector, then compare every output field to the model.
    task automatic run_vec(input logic [1:0] op, input logic [31:0] x,
                           input logic [31:0] y);
        logic [35:0] e;
        string rr;
        @(negedge clk);
        op_sel = op; a = x; b = y;
        #1;
        e = ref_model(op, x, y);
        case (op)
            2'b00: rr = "R1 add";
            2'b01: rr = "R2 sub";
            2'b10: rr = "R3 and";
            default: rr = "R4 or";
        endcase
        check(rr, result, e[31:0]);
        check("R5 negative", {31'd0, flags[3]}, {31'd0, e[35]});
        check("R6 zero", {31'd0, flags[2]}, {31'd0, e[34]});
        check(op[1] ? "R9 carry" : "R7 carry", {31'd0, flags[1]}, {31'd0, e[33]});
        check(op[1] ? "R9 overflow" : "R8 overflow", {31'd0, flags[0]}, {31'd0, e[32]});
    endtask

    task automatic direct(input string req, input logic [1:0] op,
                          input logic [31:0] x, input logic [31:0] y,
                          input logic [31:0] er, input logic [3:0] ef);
        @(negedge clk);
        op_sel = op; a = x; b = y;
        #1;
        check(req, result, er);
        check(req, {28'd0, flags}, {28'd0, ef});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] ra, rb;
        logic [1:0]  rop;
        void'($urandom(32'h0BAD_5EED));
        a = '0; b = '0; op_sel = 2'b00;
        #1;
        // Initial state: all-zero inputs give zero result and the zero flag only.
        check("R11 initial", result, 32'd0);
        check("R11 initial flags", {28'd0, flags}, 32'h4);

        // R11 fixed cases
        direct("R11 0+0", 2'b00, 32'h0, 32'h0, 32'h0, 4'h4);
        direct("R11 0+-1", 2'b00, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF, 4'h8);
        direct("R11 1+-1", 2'b00, 32'h1, 32'hFFFFFFFF, 32'h0, 4'h6);
        direct("R1 FF+1", 2'b00, 32'hFF, 32'h1, 32'h100, 4'h0);
        // R7: subtract without borrow sets carry
        direct("R7 1-1", 2'b01, 32'h1, 32'h1, 32'h0, 4'h6);
        direct("R7 0-0", 2'b01, 32'h0, 32'h0, 32'h0, 4'h6);
        direct("R7 0-(-1)", 2'b01, 32'h0, 32'hFFFFFFFF, 32'h1, 4'h0);
        direct("R2 100-1", 2'b01, 32'h100, 32'h1, 32'hFF, 4'h2);
        // R8 signed overflow corners
        direct("R8 max+1", 2'b00, 32'h7FFFFFFF, 32'h1, 32'h80000000, 4'h9);
        direct("R8 min+min", 2'b00, 32'h80000000, 32'h80000000, 32'h0, 4'h7);
        direct("R8 min-1", 2'b01, 32'h80000000, 32'h1, 32'h7FFFFFFF, 4'h3);
        direct("R8 0-min", 2'b01, 32'h0, 32'h80000000, 32'h80000000, 4'h9);
        // R3 / R4 / R9 bitwise cases
        direct("R3 and", 2'b10, 32'h12345678, 32'h87654321, 32'h02244220, 4'h0);
        direct("R3 and neg", 2'b10, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 4'h8);
        direct("R9 and zero", 2'b10, 32'h0, 32'hFFFFFFFF, 32'h0, 4'h4);
        direct("R4 or", 2'b11, 32'h12345678, 32'h87654321, 32'h97755779, 4'h8);
        direct("R9 or zero", 2'b11, 32'h0, 32'h0, 32'h0, 4'h4);
        direct("R9 or carry-like", 2'b11, 32'hFFFFFFFF, 32'h1, 32'hFFFFFFFF, 4'h8);

        // R10: two input changes within one clock phase, no edge between.
        @(posedge clk);
        #1;
        op_sel = 2'b00; a = 32'h5; b = 32'h3;
        #1;
        check("R10 first change", result, 32'h8);
        op_sel = 2'b01;
        #1;
        check("R10 second change", result, 32'h2);
        check("R10 flags", {28'd0, flags}, 32'h2);

        // Random mix, with biased operands to reach sign and carry corners.
        for (int i = 0; i < 3000; i++) begin
            rop = 2'($urandom);
            ra  = $urandom;
            rb  = $urandom;
            case (2'($urandom))
                2'd0: rb = ra;
                2'd1: rb = ~ra + 32'd1;
                2'd2: ra = {ra[31], 31'h7FFFFFFF};
                default: ;
            endcase
            run_vec(rop, ra, rb);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fails);
        $finish;
    end

endmodule